// File: doc/BRIEF.md
# PWM Channel Output Generator

This block drives one PWM output pin. It watches one of several shared free-running timer counters, chosen by a select field. The pin goes high when the chosen count equals a programmed rising-edge position. It goes low when the count equals a falling-edge position. The falling-edge position is the rising-edge position plus the integer part of a fixed-point duty word. The timers themselves, and any engine that ramps the duty over time, sit outside this block.

Software writes pending values for the rising-edge position, duty, timer select, output enable and overflow-count enable. None of them affects the pin until a one-cycle update strobe copies the whole set into the active registers at once. This means a new period shape can never mix old and new fields. The idle level and the overflow limit act directly, without waiting for the strobe.

When overflow counting is active, the block counts overflow pulses of the selected timer. After limit+1 of them it raises a one-cycle interrupt and starts counting again from zero. A one-cycle clear strobe empties the count.

Top module: `pwm_chan`

## Requirements
- R1: Reset is asynchronous and active low. It clears every active register and the overflow count. Until the first update, the pin therefore equals `idle_lvl_i` and `ovf_irq_o` is 0.
- R2: The active timer select value k (0 to 3) makes the block use count field k of `tmr_cnt_i`, which is bits [14k+13:14k], and overflow bit k of `tmr_ovf_i`.
- R3: When the selected count equals the active rising-edge position at a clock edge, the pin is 1 from that edge on. The pin rises only at such an edge.
- R4: When the selected count equals the falling-edge position at a clock edge, the pin is 0 from that edge on. The falling-edge position is (rising-edge position + duty[17:4]) mod 2^14. Duty bits [3:0] are a fraction and are ignored, and bit 18 is lost to the truncation. If both positions match at the same edge, the pin goes low.
- R5: While the active output enable is 0, the pin equals `idle_lvl_i` in the same cycle, whatever the counters do.
- R6: The pending fields have no effect until `upd_i` is high at a clock edge. From that edge on, all of them are active together.
- R7: While overflow counting is active, the edge that samples the (`ovf_lim_i`+1)-th overflow of the selected timer drives `ovf_irq_o` high for exactly one cycle. The count then restarts from 0.
- R8: Overflow pulses of unselected timers are ignored. All overflow pulses are ignored while overflow counting is inactive.
- R9: `ovf_clr_i` high at an edge sets the count to 0. This takes priority over an overflow pulse at the same edge, and no interrupt is raised at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tmr_cnt_i | input | 56 | Four packed 14-bit timer counts, timer k at [14k+13:14k] |
| tmr_ovf_i | input | 4 | Overflow pulse of each timer |
| upd_i | input | 1 | Update strobe: pending fields become active |
| pend_sel_i | input | 2 | Pending timer select |
| pend_out_en_i | input | 1 | Pending output enable |
| pend_hpt_i | input | 14 | Pending rising-edge position |
| pend_duty_i | input | 19 | Pending duty, 15 integer bits over 4 fraction bits |
| pend_ovf_en_i | input | 1 | Pending overflow-count enable |
| idle_lvl_i | input | 1 | Pin level while the output is disabled |
| ovf_lim_i | input | 10 | Overflow count limit minus one |
| ovf_clr_i | input | 1 | Clears the overflow count |
| pwm_o | output | 1 | PWM pin |
| ovf_irq_o | output | 1 | Overflow-count interrupt pulse |

## Verification
The bench drives the unselected timers with counts that reach the edge positions at other times. A design that decodes the select wrongly therefore makes the pin switch at the wrong cycles. It also places the falling-edge position past the top of the count range, and sets duty bit 18. A design that forgets the wrap, or that keeps the extra bit, then never falls where it should. Further cases cover equal edge positions, where a design with the wrong priority would hold the pin high, and pending writes made without a strobe, which a design without shadowing would apply at once. On the overflow path, the bench sends pulses from other timers and clears that coincide with a pulse. These expose an interrupt that fires early, fires on a foreign timer, or survives a clear. Limit 0 checks that every pulse fires.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;

   // Action chosen by the edge comparator for the next pin state
   typedef enum logic [1:0] {
      EDGE_HOLD = 2'd0,
      EDGE_RISE = 2'd1,
      EDGE_FALL = 2'd2
   } edge_act_e;

   localparam int unsigned DEF_CNT_W  = 14;
   localparam int unsigned DEF_DUTY_W = 19;
   localparam int unsigned DEF_FRAC_W = 4;
   localparam int unsigned DEF_OVF_W  = 10;
   localparam int unsigned DEF_NTMR   = 4;

endpackage

// File: rtl/pwm_tmr_mux.sv
module pwm_tmr_mux #(
   parameter int unsigned CNT_W = 14,
   parameter int unsigned NTMR  = 4,
   localparam int unsigned SEL_W = (NTMR > 1) ? $clog2(NTMR) : 1
) (
   input  logic [NTMR*CNT_W-1:0] cnt_bus_i,
   input  logic [NTMR-1:0]       ovf_bus_i,
   input  logic [SEL_W-1:0]      sel_i,
   output logic [CNT_W-1:0]      cnt_o,
   output logic                  ovf_o
);

   logic [CNT_W-1:0] cnt_arr [NTMR];

   for (genvar k = 0; k < NTMR; k++) begin : g_unpack
      assign cnt_arr[k] = cnt_bus_i[k*CNT_W +: CNT_W];
   end

   if ((1 << SEL_W) == NTMR) begin : g_full
      assign cnt_o = cnt_arr[sel_i];
      assign ovf_o = ovf_bus_i[sel_i];
   end else begin : g_partial
      always_comb begin
         cnt_o = '0;
         ovf_o = 1'b0;
         for (int k = 0; k < NTMR; k++) begin
            if (sel_i == SEL_W'(k)) begin
               cnt_o = cnt_arr[k];
               ovf_o = ovf_bus_i[k];
            end
         end
      end
   end

endmodule

// File: rtl/pwm_shadow.sv
module pwm_shadow #(
   parameter int unsigned CNT_W  = 14,
   parameter int unsigned DUTY_W = 19,
   parameter int unsigned FRAC_W = 4,
   parameter int unsigned SEL_W  = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              upd_i,
   input  logic [SEL_W-1:0]  pend_sel_i,
   input  logic              pend_out_en_i,
   input  logic [CNT_W-1:0]  pend_hpt_i,
   input  logic [DUTY_W-1:0] pend_duty_i,
   input  logic              pend_ovf_en_i,
   output logic [SEL_W-1:0]  act_sel_o,
   output logic              act_out_en_o,
   output logic [CNT_W-1:0]  act_hpt_o,
   output logic [CNT_W-1:0]  act_dint_o,
   output logic              act_ovf_en_o
);

   // only the integer bits that survive truncation are kept
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         act_sel_o    <= '0;
         act_out_en_o <= 1'b0;
         act_hpt_o    <= '0;
         act_dint_o   <= '0;
         act_ovf_en_o <= 1'b0;
      end else if (upd_i) begin
         act_sel_o    <= pend_sel_i;
         act_out_en_o <= pend_out_en_i;
         act_hpt_o    <= pend_hpt_i;
         act_dint_o   <= pend_duty_i[FRAC_W +: CNT_W];
         act_ovf_en_o <= pend_ovf_en_i;
      end
   end

endmodule

// File: rtl/pwm_edge_gen.sv
module pwm_edge_gen
   import pwm_chan_pkg::*;
#(
   parameter int unsigned CNT_W   = 14,
   parameter bit          REG_PIN = 1'b0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] hpt_i,
   input  logic [CNT_W-1:0] dint_i,
   input  logic             out_en_i,
   input  logic             idle_lvl_i,
   output logic             wave_o,
   output logic             pin_o
);

   logic [CNT_W-1:0] lpt;
   edge_act_e        act;

   assign lpt = hpt_i + dint_i;

   // falling match wins so a zero duty stays low
   always_comb begin
      if (cnt_i == lpt)        act = EDGE_FALL;
      else if (cnt_i == hpt_i) act = EDGE_RISE;
      else                     act = EDGE_HOLD;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                wave_o <= 1'b0;
      else if (act == EDGE_FALL)  wave_o <= 1'b0;
      else if (act == EDGE_RISE)  wave_o <= 1'b1;
   end

   if (REG_PIN) begin : g_reg_pin
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) pin_o <= 1'b0;
         else         pin_o <= out_en_i ? wave_o : idle_lvl_i;
      end
   end else begin : g_comb_pin
      assign pin_o = out_en_i ? wave_o : idle_lvl_i;
   end

endmodule

// File: rtl/pwm_ovf_cnt.sv
module pwm_ovf_cnt #(
   parameter int unsigned OVF_W = 10
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic             ovf_i,
   input  logic             clr_i,
   input  logic [OVF_W-1:0] lim_i,
   output logic             irq_o
);

   logic [OVF_W-1:0] cnt_q;
   logic             hit;

   assign hit = en_i && ovf_i && !clr_i && (cnt_q == lim_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         irq_o <= 1'b0;
      end else begin
         irq_o <= hit;
         if (clr_i || hit)       cnt_q <= '0;
         else if (en_i && ovf_i) cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
   import pwm_chan_pkg::*;
#(
   parameter int unsigned CNT_W   = DEF_CNT_W,
   parameter int unsigned DUTY_W  = DEF_DUTY_W,
   parameter int unsigned FRAC_W  = DEF_FRAC_W,
   parameter int unsigned OVF_W   = DEF_OVF_W,
   parameter int unsigned NTMR    = DEF_NTMR,
   parameter bit          REG_PIN = 1'b0,
   localparam int unsigned SEL_W  = (NTMR > 1) ? $clog2(NTMR) : 1
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic [NTMR*CNT_W-1:0] tmr_cnt_i,
   input  logic [NTMR-1:0]       tmr_ovf_i,
   input  logic                  upd_i,
   input  logic [SEL_W-1:0]      pend_sel_i,
   input  logic                  pend_out_en_i,
   input  logic [CNT_W-1:0]      pend_hpt_i,
   input  logic [DUTY_W-1:0]     pend_duty_i,
   input  logic                  pend_ovf_en_i,
   input  logic                  idle_lvl_i,
   input  logic [OVF_W-1:0]      ovf_lim_i,
   input  logic                  ovf_clr_i,
   output logic                  pwm_o,
   output logic                  ovf_irq_o
);

   if (DUTY_W < FRAC_W + CNT_W) begin : g_bad_duty
      $error("pwm_chan: DUTY_W too small for FRAC_W + CNT_W");
   end
   if (NTMR < 1) begin : g_bad_ntmr
      $error("pwm_chan: NTMR must be at least 1");
   end

   logic [SEL_W-1:0] act_sel;
   logic             act_out_en;
   logic [CNT_W-1:0] act_hpt;
   logic [CNT_W-1:0] act_dint;
   logic             act_ovf_en;
   logic [CNT_W-1:0] sel_cnt;
   logic             sel_ovf;
   logic             wave;

   pwm_shadow #(
      .CNT_W(CNT_W), .DUTY_W(DUTY_W), .FRAC_W(FRAC_W), .SEL_W(SEL_W)
   ) u_shadow (
      .clk_i(clk_i), .rst_ni(rst_ni), .upd_i(upd_i),
      .pend_sel_i(pend_sel_i), .pend_out_en_i(pend_out_en_i),
      .pend_hpt_i(pend_hpt_i), .pend_duty_i(pend_duty_i),
      .pend_ovf_en_i(pend_ovf_en_i),
      .act_sel_o(act_sel), .act_out_en_o(act_out_en),
      .act_hpt_o(act_hpt), .act_dint_o(act_dint),
      .act_ovf_en_o(act_ovf_en)
   );

   pwm_tmr_mux #(.CNT_W(CNT_W), .NTMR(NTMR)) u_mux (
      .cnt_bus_i(tmr_cnt_i), .ovf_bus_i(tmr_ovf_i), .sel_i(act_sel),
      .cnt_o(sel_cnt), .ovf_o(sel_ovf)
   );

   pwm_edge_gen #(.CNT_W(CNT_W), .REG_PIN(REG_PIN)) u_edge (
      .clk_i(clk_i), .rst_ni(rst_ni), .cnt_i(sel_cnt),
      .hpt_i(act_hpt), .dint_i(act_dint), .out_en_i(act_out_en),
      .idle_lvl_i(idle_lvl_i), .wave_o(wave), .pin_o(pwm_o)
   );

   pwm_ovf_cnt #(.OVF_W(OVF_W)) u_ovf (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(act_ovf_en), .ovf_i(sel_ovf),
      .clr_i(ovf_clr_i), .lim_i(ovf_lim_i), .irq_o(ovf_irq_o)
   );

endmodule

// File: rtl/pwm_chan_chk.sv
module pwm_chan_chk #(
   parameter int unsigned CNT_W  = 14,
   parameter int unsigned DUTY_W = 19,
   parameter int unsigned FRAC_W = 4
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              upd_i,
   input logic [CNT_W-1:0]  pend_hpt_i,
   input logic [DUTY_W-1:0] pend_duty_i,
   input logic [CNT_W-1:0]  act_hpt,
   input logic [CNT_W-1:0]  act_dint,
   input logic              act_ovf_en,
   input logic [CNT_W-1:0]  sel_cnt,
   input logic              sel_ovf,
   input logic              wave,
   input logic              ovf_clr_i,
   input logic              ovf_irq_o
);

   // R6
   hold_act_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(upd_i) |-> ($stable(act_hpt) && $stable(act_dint)));

   // R6
   load_act_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(upd_i) |-> (act_hpt == $past(pend_hpt_i)
                        && act_dint == $past(pend_duty_i[FRAC_W +: CNT_W])));

   // R3
   rise_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(wave) |-> ($past(sel_cnt) == $past(act_hpt)));

   // R4
   fall_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(wave) |-> ($past(sel_cnt) == CNT_W'($past(act_hpt) + $past(act_dint))));

   // R8
   irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf_irq_o |-> ($past(act_ovf_en) && $past(sel_ovf)));

   // R9
   clr_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(ovf_clr_i) |-> !ovf_irq_o);

endmodule

bind pwm_chan pwm_chan_chk #(
   .CNT_W(CNT_W), .DUTY_W(DUTY_W), .FRAC_W(FRAC_W)
) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .upd_i(upd_i),
   .pend_hpt_i(pend_hpt_i), .pend_duty_i(pend_duty_i),
   .act_hpt(act_hpt), .act_dint(act_dint), .act_ovf_en(act_ovf_en),
   .sel_cnt(sel_cnt), .sel_ovf(sel_ovf), .wave(wave),
   .ovf_clr_i(ovf_clr_i), .ovf_irq_o(ovf_irq_o)
);

// File: tb/pwm_chan_tb_top.sv
`timescale 1ns/1ps
module pwm_chan_tb_top;

   localparam int CW = 14;
   localparam logic [CW-1:0] MSK = '1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [CW-1:0] cnt [4];
   logic [4*CW-1:0] cnt_bus;
   logic [3:0]  ovf = '0;
   logic        upd = 1'b0, clr = 1'b0, idle = 1'b0;
   logic [1:0]  p_sel = '0;
   logic        p_en = 1'b0, p_oen = 1'b0;
   logic [CW-1:0] p_hpt = '0;
   logic [18:0] p_duty = '0;
   logic [9:0]  lim = '0;
   logic        pwm, irq;

   assign cnt_bus = {cnt[3], cnt[2], cnt[1], cnt[0]};

   pwm_chan dut_i (
      .clk_i(clk), .rst_ni(rst_n), .tmr_cnt_i(cnt_bus), .tmr_ovf_i(ovf),
      .upd_i(upd), .pend_sel_i(p_sel), .pend_out_en_i(p_en),
      .pend_hpt_i(p_hpt), .pend_duty_i(p_duty), .pend_ovf_en_i(p_oen),
      .idle_lvl_i(idle), .ovf_lim_i(lim), .ovf_clr_i(clr),
      .pwm_o(pwm), .ovf_irq_o(irq)
   );

   int checks = 0, failures = 0;

   // model of the requirements
   logic [1:0]    m_sel = '0;
   logic          m_en = 1'b0, m_oen = 1'b0, m_wave = 1'b0;
   logic [CW-1:0] m_hpt = '0, m_dint = '0;
   int            m_cnt = 0;

   logic  q_pin[$];
   logic  q_irq[$];
   string q_tag[$];

   // driver: inputs already set after a negedge; predict, push, advance
   task automatic step(input string tag);
      logic [CW-1:0] c, lpt;
      logic e_irq;
      c   = cnt[m_sel];
      lpt = (m_hpt + m_dint) & MSK;            // R4 wrap
      e_irq = 1'b0;
      if (clr) m_cnt = 0;                      // R9
      else if (m_oen && ovf[m_sel]) begin      // R8
         if (m_cnt == int'(lim)) begin e_irq = 1'b1; m_cnt = 0; end  // R7
         else m_cnt++;
      end
      if (c == lpt)        m_wave = 1'b0;
      else if (c == m_hpt) m_wave = 1'b1;
      if (upd) begin                           // R6
         m_sel = p_sel; m_en = p_en; m_oen = p_oen;
         m_hpt = p_hpt; m_dint = p_duty[17:4];
      end
      q_pin.push_back(m_en ? m_wave : idle);
      q_irq.push_back(e_irq);
      q_tag.push_back(tag);
      @(negedge clk);
      upd = 1'b0; clr = 1'b0; ovf = '0;
   endtask

   // monitor
   initial begin
      forever begin
         @(posedge clk); #5;
         if (q_pin.size() > 0) begin
            logic ep, ei; string t;
            ep = q_pin.pop_front(); ei = q_irq.pop_front(); t = q_tag.pop_front();
            checks++;
            if (pwm !== ep || irq !== ei) begin
               failures++;
               $display("FAIL %s: pin=%b irq=%b expected pin=%b irq=%b at %0t",
                        t, pwm, irq, ep, ei, $time);
            end
         end
      end
   end

   task automatic sweep(input int tmr, input logic [CW-1:0] from,
                        input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         for (int k = 0; k < 4; k++) cnt[k] = (from + CW'(i)) ^ CW'(k * 7 + 3);
         cnt[tmr] = from + CW'(i);
         step(tag);
      end
   endtask

   task automatic pulses(input logic [3:0] p, input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         ovf = p;
         step(tag);
         step(tag);
      end
   endtask

   initial begin
      for (int k = 0; k < 4; k++) cnt[k] = '0;
      idle = 1'b1;
      #35;
      checks++;                                 // R1 during reset
      if (pwm !== 1'b1 || irq !== 1'b0) begin
         failures++;
         $display("FAIL R1: pin=%b irq=%b expected pin=1 irq=0", pwm, irq);
      end
      @(negedge clk); rst_n = 1'b1;
      // R1 idle after reset, pending writes without strobe (R6)
      p_en = 1'b1; p_hpt = 14'd2; p_sel = 2'd0;
      sweep(0, 0, 4, "R1_R6_idle");
      idle = 1'b0;
      sweep(0, 0, 4, "R1_idle_low");
      // R2 R3 R4 basic window on timer 2
      p_sel = 2'd2; p_hpt = 14'd10; p_duty = {15'd20, 4'd5}; upd = 1'b1;
      step("R6_upd");
      sweep(2, 0, 40, "R2_R3_R4_basic");
      // R4 wrap past top, bit 18 dropped
      p_sel = 2'd3; p_hpt = 14'd16380; p_duty = (19'd1 << 18) | (19'd10 << 4);
      upd = 1'b1; step("R6_upd_wrap");
      sweep(3, 14'd16375, 20, "R4_wrap");
      // R4 equal positions: low wins
      p_sel = 2'd1; p_hpt = 14'd5; p_duty = 19'd7; upd = 1'b1;
      step("R6_upd_eq");
      sweep(1, 0, 12, "R4_equal");
      // R6 pending change without strobe has no effect
      p_duty = {15'd4, 4'd0}; p_hpt = 14'd2;
      sweep(1, 0, 8, "R6_no_upd");
      upd = 1'b1; step("R6_upd_late");
      sweep(1, 0, 10, "R6_after");
      // R5 disabled output follows idle
      p_en = 1'b0; upd = 1'b1; step("R5_upd");
      for (int i = 0; i < 6; i++) begin
         idle = i[0];
         sweep(1, CW'(i), 1, "R5_idle");
      end
      // overflow counting on timer 1, limit 2
      p_oen = 1'b1; p_en = 1'b1; lim = 10'd2; upd = 1'b1; step("R6_upd_ovf");
      pulses(4'b0001, 3, "R8_foreign");
      pulses(4'b0010, 6, "R7_count");
      pulses(4'b0010, 2, "R9_pre");
      clr = 1'b1; ovf = 4'b0010; step("R9_clr");
      pulses(4'b0010, 3, "R9_after");
      lim = 10'd0;
      pulses(4'b1111, 3, "R7_lim0");
      p_oen = 1'b0; upd = 1'b1; step("R8_upd_off");
      pulses(4'b0010, 3, "R8_off");
      step("drain");
      @(negedge clk);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(200000 * 20);
      failures++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule